// File: doc/BRIEF.md
# Guarded Byte Store on an APB Port

This block is a peripheral for an APB bus driven by a single requester. It holds a small byte-wide memory and serves reads and writes. Each transfer must follow the bus rules: one setup cycle, then one or more access cycles. The block tracks the bus phase from cycle to cycle, so it can tell a legal access cycle from an enable strobe that arrives without a setup cycle before it.

A transfer finishes in the access cycle in which the block raises its ready output. A parameter sets the number of wait cycles. A write is stored on the clock edge that ends its finishing cycle. A read returns the addressed byte during its finishing cycle. The block answers with an error, and changes no memory, when either of these holds:

- the byte address falls outside a configurable window (default 0x05 to 0xF1), or
- the enable strobe came without a fresh setup cycle.

Reset clears every byte and returns the phase tracker to idle.

Top module: `byte_store_apb`

## Requirements
- R1: While reset is low and after it rises, every byte reads as zero. While reset is low, ready, error and read data are all low.
- R2: A write to an in-window address followed by a read of that address returns the written byte with no error.
- R3: The window is the addresses ADDR_LO to ADDR_HI inclusive, defaults 0x05 and 0xF1. A write outside it completes with error high and stores nothing. A read outside it completes with error high.
- R4: An access cycle (select and enable high) that has no select-high, enable-low cycle before it completes at once with ready and error high, and stores nothing.
- R5: When enable stays high from a finished transfer straight into the next one, the second completes with error high and stores nothing.
- R6: A cycle with select high and enable low gives ready low and error low. Holding such cycles without ever raising enable changes no memory.
- R7: With WAIT_STATES = N (default 1), a legal transfer sees ready low for exactly N access cycles and high in the next one. A rejected enable strobe (R4, R5) sees ready high at once.
- R8: Error is high only in a cycle where select, enable and ready are all high.
- R9: An errored read drives zero read data.
- R10: A new setup cycle may follow a finished transfer at once, with no idle cycle between them, and the transfer it starts completes normally.
- R11: Read data is zero in every cycle that is not the finishing cycle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Peripheral select |
| bus_en | input | 1 | Access-phase strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid only in the finishing cycle of a read |
| bus_ready | output | 1 | Transfer finishes in this access cycle |
| bus_err | output | 1 | Transfer finished with an error |

## Verification
The assertions assume the requester holds its address, direction and write data steady from the setup cycle to the finishing cycle. They also assume it lowers select only after a finished transfer, never in the middle of wait cycles. The driver task meets both conditions. It sets every bus input once, one time unit after a rising edge, and changes nothing until it has seen ready at a falling edge. Illegal enable sequences are made only on purpose, by skipping the setup cycle. A bench model gives the expected result of each such case.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

   // Phase seen on the bus in the previous cycle
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,   // no setup pending
      PH_SETUP  = 2'd1,   // previous cycle was a setup
      PH_ACCESS = 2'd2    // legal access in progress, waiting
   } phase_t;

endpackage

// File: rtl/bsa_phase_fsm.sv
module bsa_phase_fsm
   import bsa_pkg::*;
#(
   parameter int WAIT_STATES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   input  logic en,
   output logic ready,
   output logic done,
   output logic viol
);

   generate
      if (WAIT_STATES < 0) begin : g_bad_wait
         $error("WAIT_STATES must not be negative");
      end
   endgenerate

   phase_t st_q, st_d;
   logic   legit;

   // Enable seen with a setup (or earlier waits) before it
   assign legit = sel && en && (st_q != PH_IDLE);
   // Enable seen with no setup before it
   assign viol  = sel && en && (st_q == PH_IDLE);

   generate
      if (WAIT_STATES == 0) begin : g_no_wait
         assign ready = viol || legit;
      end else begin : g_wait
         localparam int CNT_W = $clog2(WAIT_STATES + 1);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_STATES);
         logic [CNT_W-1:0] cnt_q;

         assign ready = viol || (legit && (cnt_q == LAST));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (legit && !ready) begin
               cnt_q <= cnt_q + 1'b1;
            end else begin
               cnt_q <= '0;
            end
         end

         // R7: the first legal access cycle must always wait
         assert_first_access_waits_R7: assert property (
            @(posedge clk) disable iff (!rst_n)
            (legit && st_q == PH_SETUP) |-> !ready
         );
      end
   endgenerate

   assign done = sel && en && ready;

   always_comb begin
      if (sel && !en) begin
         st_d = PH_SETUP;
      end else if (legit && !ready) begin
         st_d = PH_ACCESS;
      end else begin
         st_d = PH_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= PH_IDLE;
      end else begin
         st_q <= st_d;
      end
   end

   // R7: a waiting access must have come from a setup or earlier waits
   assert_wait_follows_setup_R7: assert property (
      @(posedge clk) disable iff (!rst_n)
      (st_q == PH_ACCESS) |-> ($past(st_q) != PH_IDLE)
   );

endmodule

// File: rtl/bsa_window.sv
module bsa_window #(
   parameter int ADDR_W  = 8,
   parameter int ADDR_LO = 5,
   parameter int ADDR_HI = 241
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);

   localparam int TOP = (1 << ADDR_W) - 1;
   localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(ADDR_LO);
   localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(ADDR_HI);

   generate
      if (ADDR_LO < 0 || ADDR_HI > TOP || ADDR_LO > ADDR_HI) begin : g_bad_win
         $error("address window out of range");
      end
   endgenerate

   logic lo_ok, hi_ok;

   generate
      if (ADDR_LO == 0) begin : g_lo_open
         assign lo_ok = 1'b1;
      end else begin : g_lo_cmp
         assign lo_ok = (addr >= LO_A);
      end
      if (ADDR_HI == TOP) begin : g_hi_open
         assign hi_ok = 1'b1;
      end else begin : g_hi_cmp
         assign hi_ok = (addr <= HI_A);
      end
   endgenerate

   assign hit = lo_ok && hi_ok;

endmodule

// File: rtl/bsa_store.sv
module bsa_store #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_aw
         $error("ADDR_W must be 1..12");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("DATA_W must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] cell_q [DEPTH];

   // One register per byte, each with its own decoded write enable
   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic hit_w;
      assign hit_w = we && (addr == ADDR_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cell_q[i] <= '0;
         end else if (hit_w) begin
            cell_q[i] <= wdata;
         end
      end
   end

   assign rdata = cell_q[addr];

endmodule

// File: rtl/byte_store_apb.sv
module byte_store_apb #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int ADDR_LO     = 5,
   parameter int ADDR_HI     = 241,
   parameter int WAIT_STATES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_en,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_ready,
   output logic              bus_err
);

   localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(ADDR_LO);
   localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(ADDR_HI);

   logic              done, viol, hit, we;
   logic [DATA_W-1:0] mem_q;

   bsa_phase_fsm #(
      .WAIT_STATES(WAIT_STATES)
   ) u_fsm (
      .clk  (clk),
      .rst_n(rst_n),
      .sel  (bus_sel),
      .en   (bus_en),
      .ready(bus_ready),
      .done (done),
      .viol (viol)
   );

   bsa_window #(
      .ADDR_W (ADDR_W),
      .ADDR_LO(ADDR_LO),
      .ADDR_HI(ADDR_HI)
   ) u_win (
      .addr(bus_addr),
      .hit (hit)
   );

   bsa_store #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (we),
      .addr (bus_addr),
      .wdata(bus_wdata),
      .rdata(mem_q)
   );

   assign bus_err   = done && (viol || !hit);
   assign we        = done && bus_write && !bus_err;
   assign bus_rdata = (done && !bus_write && !bus_err) ? mem_q : '0;

   // R3: a commit only ever lands inside the window
   assert_commit_in_window_R3: assert property (
      @(posedge clk) disable iff (!rst_n)
      we |-> (bus_addr >= LO_A && bus_addr <= HI_A)
   );

   // R4: enable without select in the cycle before is rejected
   assert_no_setup_rejected_R4: assert property (
      @(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_en && !$past(bus_sel)) |-> (bus_ready && bus_err)
   );

   // R5: enable held high straight after a finished transfer is rejected
   assert_held_enable_rejected_R5: assert property (
      @(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_en && $past(bus_sel && bus_en && bus_ready)) |-> bus_err
   );

   // R6: a setup cycle never answers
   assert_setup_silent_R6: assert property (
      @(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_en) |-> (!bus_ready && !bus_err)
   );

   // R8: error only in a finishing cycle
   assert_err_only_when_done_R8: assert property (
      @(posedge clk) disable iff (!rst_n)
      bus_err |-> (bus_sel && bus_en && bus_ready)
   );

   // R9: errored read returns zero
   assert_err_read_zero_R9: assert property (
      @(posedge clk) disable iff (!rst_n)
      (bus_err && !bus_write) |-> (bus_rdata == '0)
   );

   // R11: read data quiet outside a finishing read
   assert_rdata_quiet_R11: assert property (
      @(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_en && bus_ready && !bus_write) |-> (bus_rdata == '0)
   );

endmodule

// File: tb/byte_store_apb_bench.sv
module byte_store_apb_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WAITS      = 1;
   localparam int LO         = 5;
   localparam int HI         = 241;

   typedef struct {
      logic [7:0] rdata;
      logic       err;
      logic       wr;
      logic [7:0] addr;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_en = 1'b0, bus_write = 1'b0;
   logic [7:0] bus_addr = '0, bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       bus_ready, bus_err;

   int checks = 0;
   int errors = 0;
   exp_t expq[$];
   logic [7:0] model [256];

   byte_store_apb u_byte_store_apb (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en),
      .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // Monitor: compare every finishing cycle against the scoreboard
   always @(negedge clk) begin
      if (rst_n && bus_sel && bus_en && bus_ready) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R8", "unexpected completion", 1, 0);
         end else begin
            exp_t e;
            e = expq.pop_front();
            chk(bus_err === e.err, "R3/R4/R5", "error flag", bus_err, e.err);
            if (!e.wr) begin
               chk(bus_rdata === e.rdata, "R2/R9", "read data", bus_rdata, e.rdata);
            end
         end
      end
   end

   task automatic do_reset;
      @(posedge clk); #1;
      rst_n = 1'b0; bus_sel = 1'b0; bus_en = 1'b0;
      for (int i = 0; i < 256; i++) model[i] = '0;
      expq.delete();
      repeat (2) @(negedge clk);
      // R1: outputs quiet in reset
      chk(bus_ready == 1'b0 && bus_err == 1'b0 && bus_rdata == '0,
          "R1", "outputs in reset", {bus_ready, bus_err}, 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
   endtask

   task automatic go_idle;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_en = 1'b0;
      @(negedge clk);
      chk(bus_rdata == '0 && !bus_ready && !bus_err, "R11", "idle outputs",
          bus_rdata, 0);
   endtask

   // Driver: one transfer; skip_setup makes an illegal enable strobe
   task automatic xfer(input bit wr, input logic [7:0] a, input logic [7:0] d,
                       input bit skip_setup);
      exp_t e;
      bit   inwin;
      int   waits;
      inwin  = (a >= LO) && (a <= HI);
      e.err  = skip_setup || !inwin;
      e.wr   = wr;
      e.addr = a;
      e.rdata = (!wr && !e.err) ? model[a] : 8'h00;
      if (wr && !e.err) model[a] = d;
      expq.push_back(e);
      if (!skip_setup) begin
         @(posedge clk); #1;
         bus_sel = 1'b1; bus_en = 1'b0; bus_write = wr;
         bus_addr = a; bus_wdata = d;
      end
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_en = 1'b1; bus_write = wr;
      bus_addr = a; bus_wdata = d;
      waits = 0;
      forever begin
         @(negedge clk);
         if (bus_ready) break;
         waits++;
         chk(bus_rdata == '0 && !bus_err, "R11", "quiet during wait", bus_rdata, 0);
         if (waits > 20) break;
      end
      chk(waits == (skip_setup ? 0 : WAITS), "R7", "wait cycles", waits,
          skip_setup ? 0 : WAITS);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      chk(1'b0, "watchdog", "run hung", 0, 1);
      summary();
      $finish;
   end

   initial begin
      do_reset();

      // R1: memory cleared after reset
      xfer(0, 8'h05, 8'h00, 0);
      xfer(0, 8'h80, 8'h00, 0);
      xfer(0, 8'hF1, 8'h00, 0);
      go_idle();

      // R2, R10: writes and reads back to back, setup right after completion
      xfer(1, 8'h05, 8'hA5, 0);
      xfer(1, 8'hF1, 8'h3C, 0);
      xfer(1, 8'h80, 8'h11, 0);
      xfer(0, 8'h05, 8'h00, 0);
      xfer(0, 8'hF1, 8'h00, 0);
      xfer(0, 8'h80, 8'h00, 0);
      go_idle();

      // R3, R9: out-of-window writes and reads
      xfer(1, 8'h04, 8'h77, 0);
      xfer(1, 8'hF2, 8'h78, 0);
      xfer(1, 8'h00, 8'h79, 0);
      xfer(1, 8'hFF, 8'h7A, 0);
      xfer(0, 8'h04, 8'h00, 0);
      xfer(0, 8'hFF, 8'h00, 0);
      xfer(0, 8'h05, 8'h00, 0);
      go_idle();

      // R4: enable with no setup from idle
      xfer(1, 8'h20, 8'h99, 1);
      go_idle();
      xfer(0, 8'h20, 8'h00, 0);
      go_idle();

      // R5: enable held high into a second transfer
      xfer(1, 8'h30, 8'h12, 0);
      xfer(1, 8'h31, 8'h34, 1);
      go_idle();
      xfer(0, 8'h31, 8'h00, 0);
      xfer(0, 8'h30, 8'h00, 0);
      go_idle();

      // R6: select without enable
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_en = 1'b0; bus_write = 1'b1;
      bus_addr = 8'h40; bus_wdata = 8'hEE;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(!bus_ready && !bus_err, "R6", "setup silent", {bus_ready, bus_err}, 0);
      end
      go_idle();
      xfer(0, 8'h40, 8'h00, 0);
      go_idle();

      // R2: pattern sweep
      for (int k = 0; k < 16; k++) xfer(1, 8'(8'h50 + k * 7), 8'(k * 13 + 1), 0);
      for (int k = 0; k < 16; k++) xfer(0, 8'(8'h50 + k * 7), 8'h00, 0);
      go_idle();

      // R1: reset mid-run clears stored data
      do_reset();
      xfer(0, 8'h30, 8'h00, 0);
      xfer(0, 8'h80, 8'h00, 0);
      go_idle();

      repeat (2) @(negedge clk);
      chk(expq.size() == 0, "R8", "all completions seen", expq.size(), 0);
      summary();
      $finish;
   end

endmodule